// File: doc/BRIEF.md
# Shadowed Configuration Bank with Frame-Synchronous Commit

This block keeps a bank of 32-bit configuration words for a display compositor in two copies. Software reaches the shadow copy through a register port with valid/ready handshakes on both the request and the response side; the active copy drives the pixel logic through a flat output bus. Shadow words are copied into the active copy only at a frame boundary, signalled by a one-cycle `frame_sync` pulse. The whole bank is copied in a single clock cycle, so downstream logic never sees a mix of old and new words.

A control word picks how copies happen. By default the bank reloads itself at every frame boundary. Once software sets the reload-off bit, a copy happens only when software sets the commit bit. That bit stays set, as seen in the control word and on `load_pending`, until the copy at the next frame boundary. Hardware then clears it, so software can poll it before writing new values. After reset both copies of the bank hold zero.

The request port accepts one transfer per cycle while no read response is stalled: `req_ready` is low exactly while `rsp_valid` is high and `rsp_ready` is low. A stalled response keeps its data unchanged until it is taken. Writes produce no response. Addresses are byte addresses with a 4-byte stride. The bank window begins at `BANK_BASE` (default 0x800) and holds `BANK_WORDS` words; it may be sized up to 512 words, which ends at 0xFFC. The address width covers registers up to 0x5800.

Top module: `regbank_commit`

## Requirements
- R1: After reset every shadow and active word is zero, `load_pending` is 0, `autoload_off` is 0, and the control word (address `CTRL_ADDR`, default 0x000) reads 0.
- R2: A write to byte address `BANK_BASE + 4*i` (i < `BANK_WORDS`) stores the data in shadow word i. A read of that address returns the shadow word, with `rsp_valid` high in the cycle after the request is accepted.
- R3: While reload-off is 0, every `frame_sync` cycle copies all shadow words into the active bank, and `active_flat[32*i +: 32]` shows word i from the next cycle on.
- R4: The control word has the commit bit at bit 0 and the reload-off bit at bit 1; other bits read 0. While reload-off is 1 and no commit is pending, `frame_sync` leaves the active bank unchanged.
- R5: Writing the control word with bit 0 set makes the commit pending (`load_pending` and control bit 0 read 1). The next `frame_sync` copies the bank, and then the bit reads 0.
- R6: While a commit is pending, neither a second write of bit 0 as 1 nor a write of bit 0 as 0 changes the pending state; only the frame copy clears it.
- R7: A copy uses the shadow contents from before any write accepted in the same cycle. A commit written in the same cycle as `frame_sync` stays pending for the following frame.
- R8: The active bank changes only in a cycle in which `frame_sync` is high.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_rdata` holds and `req_ready` is low. The response clears once it is taken.
- R10: Writes to addresses that are neither the control word nor an aligned bank word change nothing, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_rdata | output | 32 | Read data |
| frame_sync | input | 1 | One-cycle frame boundary pulse |
| active_flat | output | 32*BANK_WORDS | Active bank, word i at bits 32*i+31:32*i |
| load_pending | output | 1 | Commit requested and not yet applied |
| autoload_off | output | 1 | Per-frame reload disabled |

## Verification
Read data is due one cycle after the request is accepted. The bench drives each request on a falling edge and samples `rsp_rdata` on the next falling edge. Copies land on the rising edge that sees `frame_sync` high, so the active bus and the pending flag are compared on the falling edge that follows the pulse. The bench also checks them during the idle cycles before the pulse, to confirm that nothing moves early. For the back-pressure case the response is held for several cycles and compared at each falling edge until it is released.

// File: rtl/rb_pkg.sv
package rb_pkg;
  localparam int unsigned WORD_W        = 32;
  localparam int unsigned CTRL_LOAD_BIT = 0;
  localparam int unsigned CTRL_AOFF_BIT = 1;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/rb_regport.sv
module rb_regport
  import rb_pkg::*;
#(
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned BANK_WORDS = 16,
  parameter int unsigned BANK_BASE  = 32'h800,
  parameter int unsigned CTRL_ADDR  = 32'h000,
  parameter int unsigned IDX_W      = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  word_t                 req_wdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output word_t                 rsp_rdata,
  output logic [BANK_WORDS-1:0] bank_we,
  output word_t                 wr_data,
  output logic                  ctrl_we,
  output logic [IDX_W-1:0]      rd_idx,
  input  word_t                 rd_word,
  input  word_t                 ctrl_word
);
  localparam logic [31:0] BANK_END = 32'(BANK_BASE) + 32'(4 * BANK_WORDS);

  logic [31:0] addr32;
  logic [31:0] offset;
  logic        in_bank;
  logic        is_ctrl;
  logic        fire;
  logic        wr_fire;
  logic        rd_fire;
  word_t       rd_mux;

  assign addr32  = 32'(req_addr);
  assign offset  = addr32 - 32'(BANK_BASE);
  assign in_bank = (addr32 >= 32'(BANK_BASE)) && (addr32 < BANK_END) && (addr32[1:0] == 2'b00);
  assign is_ctrl = (addr32 == 32'(CTRL_ADDR));
  assign rd_idx  = offset[IDX_W+1:2];

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign wr_fire   = fire && req_write;
  assign rd_fire   = fire && !req_write;
  assign wr_data   = req_wdata;
  assign ctrl_we   = wr_fire && is_ctrl;

  for (genvar g = 0; g < BANK_WORDS; g++) begin : g_we
    assign bank_we[g] = wr_fire && in_bank && (rd_idx == IDX_W'(g));
  end

  always_comb begin
    if (in_bank)      rd_mux = rd_word;
    else if (is_ctrl) rd_mux = ctrl_word;
    else              rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rb_ctrl.sv
module rb_ctrl
  import rb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ctrl_we,
  input  word_t wr_data,
  input  logic  frame_sync,
  output logic  pending,
  output logic  aoff,
  output logic  copy_en,
  output word_t ctrl_word
);
  logic pending_n;

  assign copy_en = frame_sync && (pending || !aoff);

  always_comb begin
    pending_n = pending;
    if (copy_en) pending_n = 1'b0;
    if (ctrl_we && wr_data[CTRL_LOAD_BIT]) pending_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      aoff    <= 1'b0;
    end else begin
      pending <= pending_n;
      if (ctrl_we) aoff <= wr_data[CTRL_AOFF_BIT];
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_LOAD_BIT] = pending;
    ctrl_word[CTRL_AOFF_BIT] = aoff;
  end
endmodule

// File: rtl/rb_bank.sv
module rb_bank
  import rb_pkg::*;
#(
  parameter int unsigned BANK_WORDS = 16,
  parameter int unsigned IDX_W      = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [BANK_WORDS-1:0]        bank_we,
  input  word_t                        wr_data,
  input  logic                         copy_en,
  input  logic [IDX_W-1:0]             rd_idx,
  output word_t                        rd_word,
  output logic [WORD_W*BANK_WORDS-1:0] active_flat
);
  word_t shadow [BANK_WORDS];
  word_t active [BANK_WORDS];

  for (genvar g = 0; g < BANK_WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow[g] <= '0;
        active[g] <= '0;
      end else begin
        if (copy_en)    active[g] <= shadow[g];
        if (bank_we[g]) shadow[g] <= wr_data;
      end
    end
    assign active_flat[WORD_W*g +: WORD_W] = active[g];
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < BANK_WORDS; i++)
      if (rd_idx == IDX_W'(i)) rd_word = shadow[i];
  end
endmodule

// File: rtl/regbank_commit.sv
module regbank_commit
  import rb_pkg::*;
#(
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned BANK_WORDS = 16,
  parameter int unsigned BANK_BASE  = 32'h800,
  parameter int unsigned CTRL_ADDR  = 32'h000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_write,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [31:0]                  req_wdata,
  output logic                         rsp_valid,
  input  logic                         rsp_ready,
  output logic [31:0]                  rsp_rdata,
  input  logic                         frame_sync,
  output logic [32*BANK_WORDS-1:0]     active_flat,
  output logic                         load_pending,
  output logic                         autoload_off
);
  localparam int unsigned IDX_W = (BANK_WORDS > 2) ? $clog2(BANK_WORDS) : 1;

  logic [BANK_WORDS-1:0] bank_we;
  word_t                 wr_data;
  logic                  ctrl_we;
  logic [IDX_W-1:0]      rd_idx;
  word_t                 rd_word;
  word_t                 ctrl_word;
  logic                  copy_en;
  logic                  load_set;

  assign load_set = ctrl_we && wr_data[CTRL_LOAD_BIT];

  rb_regport #(
    .ADDR_W(ADDR_W), .BANK_WORDS(BANK_WORDS), .BANK_BASE(BANK_BASE),
    .CTRL_ADDR(CTRL_ADDR), .IDX_W(IDX_W)
  ) u_port (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .bank_we(bank_we), .wr_data(wr_data), .ctrl_we(ctrl_we),
    .rd_idx(rd_idx), .rd_word(rd_word), .ctrl_word(ctrl_word)
  );

  rb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .wr_data(wr_data),
    .frame_sync(frame_sync), .pending(load_pending), .aoff(autoload_off),
    .copy_en(copy_en), .ctrl_word(ctrl_word)
  );

  rb_bank #(.BANK_WORDS(BANK_WORDS), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .wr_data(wr_data),
    .copy_en(copy_en), .rd_idx(rd_idx), .rd_word(rd_word),
    .active_flat(active_flat)
  );
endmodule

// File: rtl/regbank_commit_chk.sv
module regbank_commit_chk #(
  parameter int unsigned BANK_WORDS = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_ready,
  input logic                     rsp_valid,
  input logic                     rsp_ready,
  input logic [31:0]              rsp_rdata,
  input logic                     frame_sync,
  input logic [32*BANK_WORDS-1:0] active_flat,
  input logic                     load_pending,
  input logic                     autoload_off,
  input logic                     load_set
);
  p_active_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_sync |=> $stable(active_flat));

  p_no_copy_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync && autoload_off && !load_pending |=> $stable(active_flat));

  p_pending_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync && load_pending && !load_set |=> !load_pending);

  p_pending_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_pending && !frame_sync |=> load_pending);

  p_same_cycle_request_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync && load_set |=> load_pending);

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  p_ready_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);
endmodule

bind regbank_commit regbank_commit_chk #(.BANK_WORDS(BANK_WORDS)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .frame_sync(frame_sync),
  .active_flat(active_flat), .load_pending(load_pending),
  .autoload_off(autoload_off), .load_set(load_set)
);

// File: tb/test_regbank_commit.sv
module test_regbank_commit;
  localparam int unsigned ADDR_W = 15;
  localparam int unsigned NW     = 16;
  localparam int unsigned BASE   = 32'h800;
  localparam int unsigned CTRL   = 32'h000;
  localparam int unsigned AW     = 32 * NW;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b1;
  logic [31:0]       rsp_rdata;
  logic              frame_sync = 1'b0;
  logic [AW-1:0]     active_flat;
  logic              load_pending;
  logic              autoload_off;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;

  logic [31:0] sh  [NW];
  logic [31:0] act [NW];
  logic        m_pend = 1'b0;
  logic        m_aoff = 1'b0;

  always #2 clk = ~clk;

  regbank_commit i_regbank_commit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .frame_sync(frame_sync), .active_flat(active_flat),
    .load_pending(load_pending), .autoload_off(autoload_off)
  );

  task automatic check(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_active();
    logic [AW-1:0] v;
    for (int i = 0; i < NW; i++) v[32*i +: 32] = act[i];
    return v;
  endfunction

  function automatic logic [31:0] exp_ctrl();
    return {30'd0, m_aoff, m_pend};
  endfunction

  // Model: copy with state before this cycle's write, then apply write.
  task automatic model(input logic wr, input logic [31:0] a, input logic [31:0] d, input logic sync);
    if (sync && (m_pend || !m_aoff)) begin
      for (int i = 0; i < NW; i++) act[i] = sh[i];
      m_pend = 1'b0;
    end
    if (wr) begin
      if (a == CTRL) begin
        if (d[0]) m_pend = 1'b1;
        m_aoff = d[1];
      end else if (a >= BASE && a < BASE + 4 * NW && a[1:0] == 2'b00) begin
        sh[(a - BASE) >> 2] = d;
      end
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic sync);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a[ADDR_W-1:0]; req_wdata = d;
    frame_sync = sync;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; frame_sync = 1'b0;
    model(1'b1, a, d, sync);
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a[ADDR_W-1:0];
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
  endtask

  task automatic sync_pulse();
    @(negedge clk);
    frame_sync = 1'b1;
    @(negedge clk);
    frame_sync = 1'b0;
    model(1'b0, 32'h0, 32'h0, 1'b1);
  endtask

  task automatic check_shadow(input string req);
    logic [31:0] d;
    for (int i = 0; i < NW; i++) begin
      rd(BASE + 4 * i, d);
      check(req, AW'(d), AW'(sh[i]));
    end
  endtask

  task automatic fill(input logic [31:0] seed);
    for (int i = 0; i < NW; i++)
      wr(BASE + 4 * i, seed ^ (32'h01010101 * i) + 32'(i * 7), 1'b0);
  endtask

  initial begin
    logic [31:0] d;
    logic [31:0] held;
    for (int i = 0; i < NW; i++) begin sh[i] = '0; act[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 active", active_flat, '0);
    check("R1 pending", AW'(load_pending), '0);
    check("R1 autoload_off", AW'(autoload_off), '0);
    rd(CTRL, d); check("R1 ctrl", AW'(d), '0);
    check_shadow("R1 shadow");

    // R2 writes to shadow, read back; R8 active untouched
    fill(32'hA5C30000);
    check_shadow("R2 readback");
    check("R8 no early copy", active_flat, '0);

    // R3 autoload copy on each frame
    sync_pulse();
    check("R3 copy", active_flat, exp_active());
    fill(32'h5A3C1111);
    check("R8 hold before frame", active_flat, exp_active());
    sync_pulse();
    check("R3 second copy", active_flat, exp_active());

    // R4 reload off: frame without commit leaves active
    wr(CTRL, 32'h2, 1'b0);
    rd(CTRL, d); check("R4 ctrl reads", AW'(d), AW'(exp_ctrl()));
    check("R4 autoload_off", AW'(autoload_off), AW'(1'b1));
    fill(32'h0F0F2222);
    sync_pulse();
    check("R4 no copy", active_flat, exp_active());

    // R5 explicit commit
    wr(CTRL, 32'h3, 1'b0);
    check("R5 pending set", AW'(load_pending), AW'(1'b1));
    rd(CTRL, d); check("R5 ctrl pending", AW'(d), AW'(32'h3));
    repeat (4) @(negedge clk);
    check("R8 idle no copy", active_flat, exp_active());
    sync_pulse();
    check("R5 commit copy", active_flat, exp_active());
    rd(CTRL, d); check("R5 ctrl cleared", AW'(d), AW'(32'h2));

    // R6 repeated / zero writes while pending
    wr(CTRL, 32'h3, 1'b0);
    wr(CTRL, 32'h2, 1'b0);
    check("R6 zero write keeps pending", AW'(load_pending), AW'(1'b1));
    wr(CTRL, 32'h3, 1'b0);
    check("R6 rewrite keeps pending", AW'(load_pending), AW'(1'b1));
    fill(32'h33330000);
    sync_pulse();
    check("R6 single copy", active_flat, exp_active());
    check("R6 cleared by copy", AW'(load_pending), '0);

    // R7 same-cycle shadow write not in copy
    wr(CTRL, 32'h3, 1'b0);
    wr(BASE, 32'hDEADBEEF, 1'b1);
    check("R7 copy uses old shadow", active_flat, exp_active());
    check("R7 pending cleared", AW'(load_pending), '0);
    // R7 commit in same cycle as frame stays pending
    wr(CTRL, 32'h3, 1'b1);
    check("R7 request survives frame", AW'(load_pending), AW'(1'b1));
    check("R7 no copy yet", active_flat, exp_active());
    sync_pulse();
    check("R7 next frame copy", active_flat, exp_active());

    // R10 unmapped accesses
    wr(32'h100, 32'hFFFFFFFF, 1'b0);
    wr(BASE + 4 * NW, 32'hFFFFFFFF, 1'b0);
    wr(BASE + 2, 32'hFFFFFFFF, 1'b0);
    check_shadow("R10 shadow untouched");
    rd(CTRL, d); check("R10 ctrl untouched", AW'(d), AW'(exp_ctrl()));
    rd(32'h100, d); check("R10 read zero", AW'(d), '0);
    rd(BASE + 4 * NW, d); check("R10 read past bank", AW'(d), '0);

    // R9 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = ADDR_W'(BASE + 4);
    @(negedge clk);
    req_valid = 1'b0;
    held = rsp_rdata;
    check("R9 data", AW'(held), AW'(sh[1]));
    for (int k = 0; k < 3; k++) begin
      check("R9 valid held", AW'(rsp_valid), AW'(1'b1));
      check("R9 ready low", AW'(req_ready), '0);
      check("R9 data stable", AW'(rsp_rdata), AW'(held));
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R9 released", AW'(rsp_valid), '0);

    // R3 reload re-enabled
    wr(CTRL, 32'h0, 1'b0);
    fill(32'h77770000);
    sync_pulse();
    check("R3 copy after re-enable", active_flat, exp_active());

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule